// File: doc/BRIEF.md
# Floating-Point and Vector Status Register Unit

This block holds the user-level status and control state shared by a core's floating-point unit and its fixed-point vector unit: the FP rounding mode, the five FP accrued exception flags, the vector fixed-point rounding mode, the saturation flag, the vector start index, the vector length and the vector type. Software reaches this state through a register port with a 12-bit address, separate read and write strobes, write data, read data and an illegal-access flag. Several addresses are different views of the same storage, so a write through one view is seen through all the others.

Every access is checked before it takes effect. Floating-point views are refused while the 2-bit FP status field supplied by the core is off, unless the core is in debug mode. Read-only vector registers refuse writes. Addresses that do not exist in the chosen build are refused. A successful write to a floating-point view asks the core to set its FP status field to dirty. The vector datapath has its own side port to set the saturation flag and to load the length and type registers. A build parameter selects one of three variants: FP only, vector only, or both.

Read data, the illegal flag and the dirty request are registered. They appear on the clock edge that follows the cycle in which the strobe was presented.

Top module: `fpv_status_csr`

## Requirements
- R1: The address map is as follows. 0x001 is the flags view, 0x002 the FP rounding view, 0x003 the packed control view, 0x008 vector start, 0x009 saturation, 0x00A vector rounding, 0xC20 vector length and 0xC21 vector type. The packed view holds the flags in bits 4:0, the FP rounding mode in bits 7:5, saturation in bit 8 and the vector rounding mode in bits 10:9. All other bits read as zero.
- R2: The flags, FP rounding, saturation and vector rounding views alias the matching fields of the packed view in both directions.
- R3: A write stores only the field width taken from the low bits of the write data: 5 bits for flags, 3 for FP rounding, 2 for vector rounding and 1 for saturation. A write to the vector rounding or saturation view does not request a dirty update.
- R4: An access to 0x001, 0x002 or 0x003 while the FP status input is 2'b00 and debug mode is low is illegal and leaves all state unchanged. In debug mode the same access proceeds. Vector-only addresses are not gated by the FP status.
- R5: A successful write to 0x001, 0x002 or 0x003 pulses the update-valid output for one cycle, with the update value 2'b11 (dirty). No other access pulses it.
- R6: Vector length and vector type are read-only: a write to either is illegal and changes nothing. Vector start is read/write and keeps VSTART_W bits.
- R7: In the vector-only build, 0x001 and 0x002 are illegal, and the FP fields of the packed view read zero and ignore writes. In the FP-only build, all vector addresses are illegal and the vector fields of the packed view read zero.
- R8: The side port sets saturation to 1 and loads length and type. When a legal register write targets saturation in the same cycle as a set request, the register write wins.
- R9: Reset clears every held field to zero and drives the illegal flag, the update-valid output and the read data to zero.
- R10: Outputs respond one cycle after the strobe. An access to an unmapped address is illegal. An illegal access returns zero read data. A legal read returns the value held before any write in the same cycle. Cycles with no strobe raise neither the illegal flag nor the update-valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 12 | Register address |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, registered |
| csr_illegal | output | 1 | Access refused, registered |
| fs_state | input | 2 | Current FP status field from the core |
| dbg_mode | input | 1 | Core is in debug mode |
| fs_upd_valid | output | 1 | One-cycle request to update the FP status field |
| fs_upd_value | output | 2 | New FP status value (2'b11 when valid) |
| vx_sat_set | input | 1 | Side port: set the saturation flag |
| vl_load | input | 1 | Side port: load vector length and type |
| vl_new | input | VL_W | Side port: new vector length |
| vtype_new | input | VTYPE_W | Side port: new vector type |

## Verification
The bench walks a chain of writes and reads through every view. An aliasing bug leaves a stale field in the packed view, and a masking bug leaks high write bits into a field. It presents FP accesses with the status off, both in and out of debug mode, and then reads the state back. A design that ignores the gate would change state, and one that ignores the debug bypass would refuse a legal debug access. It also writes the read-only vector registers, and it sets saturation from the side port in the same cycle as a clearing register write, where the wrong priority leaves saturation at one. Three instances, one per build, are compared on the packed view and on the addresses each variant must refuse.

// File: rtl/fpv_csr_pkg.sv
package fpv_csr_pkg;

   localparam int BUILD_FP  = 0;
   localparam int BUILD_VEC = 1;
   localparam int BUILD_FPV = 2;

   localparam logic [11:0] ADR_FLAGS  = 12'h001;
   localparam logic [11:0] ADR_FRM    = 12'h002;
   localparam logic [11:0] ADR_FCTL   = 12'h003;
   localparam logic [11:0] ADR_VSTART = 12'h008;
   localparam logic [11:0] ADR_VSAT   = 12'h009;
   localparam logic [11:0] ADR_VRND   = 12'h00A;
   localparam logic [11:0] ADR_VLEN   = 12'hC20;
   localparam logic [11:0] ADR_VTYPE  = 12'hC21;

   localparam int FLAGS_W   = 5;
   localparam int FRM_W     = 3;
   localparam int VRND_W    = 2;
   localparam int FLAGS_LSB = 0;
   localparam int FRM_LSB   = 5;
   localparam int VSAT_BIT  = 8;
   localparam int VRND_LSB  = 9;
   localparam int FCTL_W    = VRND_LSB + VRND_W;

   localparam logic [1:0] FS_OFF   = 2'b00;
   localparam logic [1:0] FS_DIRTY = 2'b11;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_FLAGS, SEL_FRM, SEL_FCTL,
      SEL_VSTART, SEL_VSAT, SEL_VRND, SEL_VLEN, SEL_VTYPE
   } sel_e;

   typedef struct packed {
      logic flags;
      logic frm;
      logic vrnd;
      logic vsat;
      logic vstart;
   } wen_t;

endpackage

// File: rtl/fpv_csr_decode.sv
module fpv_csr_decode
   import fpv_csr_pkg::*;
#(
   parameter bit HAS_FP  = 1'b1,
   parameter bit HAS_VEC = 1'b1
) (
   input  logic [11:0] addr,
   input  logic        rd,
   input  logic        wr,
   input  logic [1:0]  fs_state,
   input  logic        dbg_mode,
   output sel_e        sel,
   output logic        illegal,
   output logic        rd_ok,
   output wen_t        wen,
   output logic        mark_dirty
);

   logic access, is_fp, fs_block, ro_viol, do_wr, fctl;

   always_comb begin
      sel = SEL_NONE;
      case (addr)
         ADR_FLAGS:  if (HAS_FP)  sel = SEL_FLAGS;
         ADR_FRM:    if (HAS_FP)  sel = SEL_FRM;
         ADR_FCTL:                sel = SEL_FCTL;
         ADR_VSTART: if (HAS_VEC) sel = SEL_VSTART;
         ADR_VSAT:   if (HAS_VEC) sel = SEL_VSAT;
         ADR_VRND:   if (HAS_VEC) sel = SEL_VRND;
         ADR_VLEN:   if (HAS_VEC) sel = SEL_VLEN;
         ADR_VTYPE:  if (HAS_VEC) sel = SEL_VTYPE;
         default:                 sel = SEL_NONE;
      endcase
   end

   always_comb begin
      access   = rd | wr;
      fctl     = (sel == SEL_FCTL);
      is_fp    = (sel == SEL_FLAGS) | (sel == SEL_FRM) | fctl;
      fs_block = is_fp & ~dbg_mode & (fs_state == FS_OFF);
      ro_viol  = wr & ((sel == SEL_VLEN) | (sel == SEL_VTYPE));
      illegal  = access & ((sel == SEL_NONE) | fs_block | ro_viol);
      rd_ok    = rd & ~illegal;
      do_wr    = wr & ~illegal;
      wen.flags  = do_wr & ((sel == SEL_FLAGS) | (fctl & HAS_FP));
      wen.frm    = do_wr & ((sel == SEL_FRM)   | (fctl & HAS_FP));
      wen.vrnd   = do_wr & ((sel == SEL_VRND)  | (fctl & HAS_VEC));
      wen.vsat   = do_wr & ((sel == SEL_VSAT)  | (fctl & HAS_VEC));
      wen.vstart = do_wr & (sel == SEL_VSTART);
      mark_dirty = do_wr & is_fp;
   end

endmodule

// File: rtl/fpv_csr_fields.sv
module fpv_csr_fields
   import fpv_csr_pkg::*;
#(
   parameter bit HAS_FP   = 1'b1,
   parameter bit HAS_VEC  = 1'b1,
   parameter int XLEN     = 32,
   parameter int VSTART_W = 8,
   parameter int VL_W     = 8,
   parameter int VTYPE_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  wen_t                wen,
   input  logic                from_fctl,
   input  logic [XLEN-1:0]     wdata,
   input  logic                sat_set,
   input  logic                vl_load,
   input  logic [VL_W-1:0]     vl_new,
   input  logic [VTYPE_W-1:0]  vtype_new,
   output logic [FLAGS_W-1:0]  flags_q,
   output logic [FRM_W-1:0]    frm_q,
   output logic [VRND_W-1:0]   vrnd_q,
   output logic                vsat_q,
   output logic [VSTART_W-1:0] vstart_q,
   output logic [VL_W-1:0]     vl_q,
   output logic [VTYPE_W-1:0]  vtype_q
);

   logic [FLAGS_W-1:0] flags_d;
   logic [FRM_W-1:0]   frm_d;
   logic [VRND_W-1:0]  vrnd_d;
   logic               vsat_d;
   logic               unused_wdata;

   assign unused_wdata = ^wdata;

   always_comb begin
      flags_d = from_fctl ? wdata[FLAGS_LSB +: FLAGS_W] : wdata[FLAGS_W-1:0];
      frm_d   = from_fctl ? wdata[FRM_LSB +: FRM_W]     : wdata[FRM_W-1:0];
      vrnd_d  = from_fctl ? wdata[VRND_LSB +: VRND_W]   : wdata[VRND_W-1:0];
      vsat_d  = from_fctl ? wdata[VSAT_BIT]             : wdata[0];
   end

   if (HAS_FP) begin : g_fp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags_q <= '0;
            frm_q   <= '0;
         end else begin
            if (wen.flags) flags_q <= flags_d;
            if (wen.frm)   frm_q   <= frm_d;
         end
      end
   end else begin : g_no_fp
      logic unused_fp;
      assign unused_fp = ^{wen.flags, wen.frm, flags_d, frm_d};
      assign flags_q = '0;
      assign frm_q   = '0;
   end

   if (HAS_VEC) begin : g_vec
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vrnd_q   <= '0;
            vsat_q   <= 1'b0;
            vstart_q <= '0;
            vl_q     <= '0;
            vtype_q  <= '0;
         end else begin
            if (wen.vrnd)   vrnd_q   <= vrnd_d;
            if (wen.vsat)   vsat_q   <= vsat_d;
            else if (sat_set) vsat_q <= 1'b1;
            if (wen.vstart) vstart_q <= wdata[VSTART_W-1:0];
            if (vl_load) begin
               vl_q    <= vl_new;
               vtype_q <= vtype_new;
            end
         end
      end
   end else begin : g_no_vec
      logic unused_vec;
      assign unused_vec = ^{wen.vrnd, wen.vsat, wen.vstart, vrnd_d, vsat_d,
                            sat_set, vl_load, vl_new, vtype_new};
      assign vrnd_q   = '0;
      assign vsat_q   = 1'b0;
      assign vstart_q = '0;
      assign vl_q     = '0;
      assign vtype_q  = '0;
   end

endmodule

// File: rtl/fpv_csr_rdmux.sv
module fpv_csr_rdmux
   import fpv_csr_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int VSTART_W = 8,
   parameter int VL_W     = 8,
   parameter int VTYPE_W  = 8
) (
   input  sel_e                sel,
   input  logic [FLAGS_W-1:0]  flags_q,
   input  logic [FRM_W-1:0]    frm_q,
   input  logic [VRND_W-1:0]   vrnd_q,
   input  logic                vsat_q,
   input  logic [VSTART_W-1:0] vstart_q,
   input  logic [VL_W-1:0]     vl_q,
   input  logic [VTYPE_W-1:0]  vtype_q,
   output logic [XLEN-1:0]     value
);

   always_comb begin
      value = '0;
      case (sel)
         SEL_FLAGS:  value[FLAGS_W-1:0] = flags_q;
         SEL_FRM:    value[FRM_W-1:0]   = frm_q;
         SEL_FCTL: begin
            value[FLAGS_LSB +: FLAGS_W] = flags_q;
            value[FRM_LSB +: FRM_W]     = frm_q;
            value[VSAT_BIT]             = vsat_q;
            value[VRND_LSB +: VRND_W]   = vrnd_q;
         end
         SEL_VSTART: value[VSTART_W-1:0] = vstart_q;
         SEL_VSAT:   value[0]            = vsat_q;
         SEL_VRND:   value[VRND_W-1:0]   = vrnd_q;
         SEL_VLEN:   value[VL_W-1:0]     = vl_q;
         SEL_VTYPE:  value[VTYPE_W-1:0]  = vtype_q;
         default:    value = '0;
      endcase
   end

endmodule

// File: rtl/fpv_status_csr.sv
module fpv_status_csr
   import fpv_csr_pkg::*;
#(
   parameter int BUILD    = BUILD_FPV,
   parameter int XLEN     = 32,
   parameter int VSTART_W = 8,
   parameter int VL_W     = 8,
   parameter int VTYPE_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [11:0]        csr_addr,
   input  logic               csr_rd,
   input  logic               csr_wr,
   input  logic [XLEN-1:0]    csr_wdata,
   output logic [XLEN-1:0]    csr_rdata,
   output logic               csr_illegal,
   input  logic [1:0]         fs_state,
   input  logic               dbg_mode,
   output logic               fs_upd_valid,
   output logic [1:0]         fs_upd_value,
   input  logic               vx_sat_set,
   input  logic               vl_load,
   input  logic [VL_W-1:0]    vl_new,
   input  logic [VTYPE_W-1:0] vtype_new
);

   localparam bit HAS_FP  = (BUILD != BUILD_VEC);
   localparam bit HAS_VEC = (BUILD != BUILD_FP);

   if (BUILD < BUILD_FP || BUILD > BUILD_FPV) begin : g_bad_build
      $error("BUILD must select FP only, vector only or both");
   end
   if (XLEN < FCTL_W) begin : g_bad_xlen
      $error("XLEN too narrow for the packed control view");
   end
   if (VSTART_W > XLEN || VL_W > XLEN || VTYPE_W > XLEN || VSTART_W < 1) begin : g_bad_w
      $error("vector field widths must lie between 1 and XLEN");
   end

   sel_e               sel;
   logic               illegal, rd_ok, mark_dirty;
   wen_t               wen;
   logic [FLAGS_W-1:0] flags_q;
   logic [FRM_W-1:0]   frm_q;
   logic [VRND_W-1:0]  vrnd_q;
   logic               vsat_q;
   logic [VSTART_W-1:0] vstart_q;
   logic [VL_W-1:0]    vl_q;
   logic [VTYPE_W-1:0] vtype_q;
   logic [XLEN-1:0]    rd_value;

   fpv_csr_decode #(.HAS_FP(HAS_FP), .HAS_VEC(HAS_VEC)) u_dec (
      .addr(csr_addr), .rd(csr_rd), .wr(csr_wr), .fs_state(fs_state),
      .dbg_mode(dbg_mode), .sel(sel), .illegal(illegal), .rd_ok(rd_ok),
      .wen(wen), .mark_dirty(mark_dirty)
   );

   fpv_csr_fields #(
      .HAS_FP(HAS_FP), .HAS_VEC(HAS_VEC), .XLEN(XLEN),
      .VSTART_W(VSTART_W), .VL_W(VL_W), .VTYPE_W(VTYPE_W)
   ) u_fld (
      .clk(clk), .rst_n(rst_n), .wen(wen), .from_fctl(sel == SEL_FCTL),
      .wdata(csr_wdata), .sat_set(vx_sat_set), .vl_load(vl_load),
      .vl_new(vl_new), .vtype_new(vtype_new), .flags_q(flags_q),
      .frm_q(frm_q), .vrnd_q(vrnd_q), .vsat_q(vsat_q), .vstart_q(vstart_q),
      .vl_q(vl_q), .vtype_q(vtype_q)
   );

   fpv_csr_rdmux #(
      .XLEN(XLEN), .VSTART_W(VSTART_W), .VL_W(VL_W), .VTYPE_W(VTYPE_W)
   ) u_mux (
      .sel(sel), .flags_q(flags_q), .frm_q(frm_q), .vrnd_q(vrnd_q),
      .vsat_q(vsat_q), .vstart_q(vstart_q), .vl_q(vl_q), .vtype_q(vtype_q),
      .value(rd_value)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csr_rdata    <= '0;
         csr_illegal  <= 1'b0;
         fs_upd_valid <= 1'b0;
         fs_upd_value <= FS_OFF;
      end else begin
         csr_rdata    <= rd_ok ? rd_value : '0;
         csr_illegal  <= illegal;
         fs_upd_valid <= mark_dirty;
         fs_upd_value <= mark_dirty ? FS_DIRTY : FS_OFF;
      end
   end

endmodule

// File: rtl/fpv_csr_checker.sv
module fpv_csr_checker #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [11:0]     csr_addr,
   input logic            csr_rd,
   input logic            csr_wr,
   input logic [1:0]      fs_state,
   input logic            dbg_mode,
   input logic [XLEN-1:0] csr_rdata,
   input logic            csr_illegal,
   input logic            fs_upd_valid,
   input logic [1:0]      fs_upd_value
);

   logic fp_addr, ro_addr;
   assign fp_addr = (csr_addr == 12'h001) || (csr_addr == 12'h002) || (csr_addr == 12'h003);
   assign ro_addr = (csr_addr == 12'hC20) || (csr_addr == 12'hC21);

   AST_FS_OFF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      ((csr_rd || csr_wr) && fp_addr && !dbg_mode && fs_state == 2'b00) |=> csr_illegal); // R4

   AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && ro_addr) |=> csr_illegal); // R6

   AST_DIRTY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      fs_upd_valid |-> (fs_upd_value == 2'b11 && !csr_illegal)); // R5

   AST_DIRTY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      fs_upd_valid |-> ($past(csr_wr) && ($past(csr_addr) == 12'h001 ||
                        $past(csr_addr) == 12'h002 || $past(csr_addr) == 12'h003))); // R5

   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      csr_illegal |-> (csr_rdata == '0)); // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(csr_rd || csr_wr) |=> (!csr_illegal && !fs_upd_valid)); // R10

endmodule

bind fpv_status_csr fpv_csr_checker #(.XLEN(XLEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd),
   .csr_wr(csr_wr), .fs_state(fs_state), .dbg_mode(dbg_mode),
   .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
   .fs_upd_valid(fs_upd_valid), .fs_upd_value(fs_upd_value)
);

// File: tb/fpv_status_csr_test.sv
module fpv_status_csr_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        rd = 1'b0, wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [1:0]  fs = 2'b01;
   logic        dbg = 1'b0;
   logic        sat_set = 1'b0, vl_load = 1'b0;
   logic [7:0]  vl_new = '0, vtype_new = '0;

   logic [31:0] rdata, rdata_v, rdata_f;
   logic        ill, ill_v, ill_f;
   logic        upd, upd_v, upd_f;
   logic [1:0]  updv, updv_v, updv_f;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fpv_status_csr #(.BUILD(2)) uut (
      .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_rd(rd), .csr_wr(wr),
      .csr_wdata(wdata), .csr_rdata(rdata), .csr_illegal(ill), .fs_state(fs),
      .dbg_mode(dbg), .fs_upd_valid(upd), .fs_upd_value(updv),
      .vx_sat_set(sat_set), .vl_load(vl_load), .vl_new(vl_new), .vtype_new(vtype_new));

   fpv_status_csr #(.BUILD(1)) uut_v (
      .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_rd(rd), .csr_wr(wr),
      .csr_wdata(wdata), .csr_rdata(rdata_v), .csr_illegal(ill_v), .fs_state(fs),
      .dbg_mode(dbg), .fs_upd_valid(upd_v), .fs_upd_value(updv_v),
      .vx_sat_set(sat_set), .vl_load(vl_load), .vl_new(vl_new), .vtype_new(vtype_new));

   fpv_status_csr #(.BUILD(0)) uut_f (
      .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_rd(rd), .csr_wr(wr),
      .csr_wdata(wdata), .csr_rdata(rdata_f), .csr_illegal(ill_f), .fs_state(fs),
      .dbg_mode(dbg), .fs_upd_valid(upd_f), .fs_upd_value(updv_f),
      .vx_sat_set(sat_set), .vl_load(vl_load), .vl_new(vl_new), .vtype_new(vtype_new));

   typedef struct packed {
      logic        rd;
      logic        wr;
      logic [11:0] addr;
      logic [31:0] wd;
      logic [1:0]  fs;
      logic        dbg;
      logic        ill;
      logic [31:0] rdat;
      logic        dirty;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t TBL [NV] = '{
      '{1'b1,1'b0,12'h003,32'h0,       2'd1,1'b0, 1'b0,32'h0,  1'b0}, // R1 cleared
      '{1'b0,1'b1,12'h003,32'hFFFFFFFF,2'd1,1'b0, 1'b0,32'h0,  1'b1}, // R5
      '{1'b1,1'b0,12'h003,32'h0,       2'd1,1'b0, 1'b0,32'h7FF,1'b0}, // R1 packing
      '{1'b1,1'b0,12'h001,32'h0,       2'd1,1'b0, 1'b0,32'h1F, 1'b0}, // R2
      '{1'b1,1'b0,12'h002,32'h0,       2'd1,1'b0, 1'b0,32'h7,  1'b0}, // R2
      '{1'b1,1'b0,12'h00A,32'h0,       2'd1,1'b0, 1'b0,32'h3,  1'b0}, // R2
      '{1'b1,1'b0,12'h009,32'h0,       2'd1,1'b0, 1'b0,32'h1,  1'b0}, // R2
      '{1'b0,1'b1,12'h002,32'hF2,      2'd1,1'b0, 1'b0,32'h0,  1'b1}, // R3
      '{1'b1,1'b0,12'h003,32'h0,       2'd1,1'b0, 1'b0,32'h75F,1'b0}, // R2
      '{1'b0,1'b1,12'h001,32'h24,      2'd1,1'b0, 1'b0,32'h0,  1'b1}, // R3
      '{1'b1,1'b0,12'h003,32'h0,       2'd1,1'b0, 1'b0,32'h744,1'b0}, // R2
      '{1'b0,1'b1,12'h00A,32'h6,       2'd1,1'b0, 1'b0,32'h0,  1'b0}, // R3
      '{1'b0,1'b1,12'h009,32'h2,       2'd1,1'b0, 1'b0,32'h0,  1'b0}, // R3
      '{1'b1,1'b0,12'h003,32'h0,       2'd1,1'b0, 1'b0,32'h444,1'b0}, // R2
      '{1'b0,1'b1,12'h008,32'hFFFF,    2'd1,1'b0, 1'b0,32'h0,  1'b0}, // R6
      '{1'b1,1'b0,12'h008,32'h0,       2'd1,1'b0, 1'b0,32'hFF, 1'b0}, // R6
      '{1'b0,1'b1,12'hC20,32'h5,       2'd1,1'b0, 1'b1,32'h0,  1'b0}, // R6
      '{1'b1,1'b0,12'hC20,32'h0,       2'd1,1'b0, 1'b0,32'h0,  1'b0}, // R6
      '{1'b0,1'b1,12'hC21,32'h5,       2'd1,1'b0, 1'b1,32'h0,  1'b0}, // R6
      '{1'b1,1'b0,12'h123,32'h0,       2'd1,1'b0, 1'b1,32'h0,  1'b0}, // R10
      '{1'b0,1'b1,12'h002,32'h7,       2'd0,1'b0, 1'b1,32'h0,  1'b0}, // R4
      '{1'b1,1'b0,12'h002,32'h0,       2'd0,1'b0, 1'b1,32'h0,  1'b0}, // R4
      '{1'b1,1'b0,12'h002,32'h0,       2'd0,1'b1, 1'b0,32'h2,  1'b0}, // R4
      '{1'b0,1'b1,12'h002,32'h5,       2'd0,1'b1, 1'b0,32'h0,  1'b1}, // R4
      '{1'b1,1'b0,12'h009,32'h0,       2'd0,1'b0, 1'b0,32'h0,  1'b0}, // R4
      '{1'b1,1'b1,12'h002,32'h3,       2'd1,1'b0, 1'b0,32'h5,  1'b1}, // R10
      '{1'b1,1'b0,12'h002,32'h0,       2'd1,1'b0, 1'b0,32'h3,  1'b0}, // R10
      '{1'b0,1'b1,12'h003,32'h0,       2'd0,1'b0, 1'b1,32'h0,  1'b0}, // R4
      '{1'b1,1'b0,12'h003,32'h0,       2'd1,1'b0, 1'b0,32'h464,1'b0}  // R4
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic op(input logic r, input logic w, input logic [11:0] a,
                     input logic [31:0] d);
      @(negedge clk);
      rd = r; wr = w; addr = a; wdata = d;
      @(negedge clk);
      rd = 1'b0; wr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 rdata at reset", rdata, 32'h0);
      check("R9 illegal at reset", {31'b0, ill}, 32'h0);
      check("R9 update at reset", {31'b0, upd}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 idle after reset", {30'b0, ill, upd}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         fs = TBL[i].fs; dbg = TBL[i].dbg;
         op(TBL[i].rd, TBL[i].wr, TBL[i].addr, TBL[i].wd);
         check($sformatf("R table row %0d illegal", i), {31'b0, ill}, {31'b0, TBL[i].ill});
         check($sformatf("R table row %0d rdata", i), rdata, TBL[i].rdat);
         check($sformatf("R table row %0d dirty", i), {31'b0, upd}, {31'b0, TBL[i].dirty});
         if (TBL[i].dirty) check("R5 dirty value", {30'b0, updv}, 32'h3);
      end
      fs = 2'd1; dbg = 1'b0;

      // R8 side port loads length and type
      @(negedge clk);
      vl_load = 1'b1; vl_new = 8'd9; vtype_new = 8'h45;
      @(negedge clk);
      vl_load = 1'b0;
      op(1'b1, 1'b0, 12'hC20, 32'h0);
      check("R8 length load", rdata, 32'd9);
      op(1'b1, 1'b0, 12'hC21, 32'h0);
      check("R8 type load", rdata, 32'h45);

      // R8 saturation set alone
      @(negedge clk);
      sat_set = 1'b1;
      @(negedge clk);
      sat_set = 1'b0;
      op(1'b1, 1'b0, 12'h009, 32'h0);
      check("R8 saturation set", rdata, 32'h1);

      // R8 register write beats side set
      @(negedge clk);
      sat_set = 1'b1; wr = 1'b1; addr = 12'h009; wdata = 32'h0;
      @(negedge clk);
      sat_set = 1'b0; wr = 1'b0;
      op(1'b1, 1'b0, 12'h009, 32'h0);
      check("R8 write priority", rdata, 32'h0);

      // R7 build variants
      op(1'b0, 1'b1, 12'h003, 32'h0000_0FFF);
      check("R7 vec-only packed write dirty", {31'b0, upd_v}, 32'h1);
      op(1'b1, 1'b0, 12'h003, 32'h0);
      check("R7 both packed", rdata, 32'h7FF);
      check("R7 vec-only packed", rdata_v, 32'h700);
      check("R7 fp-only packed", rdata_f, 32'h0FF);
      op(1'b1, 1'b0, 12'h001, 32'h0);
      check("R7 vec-only flags illegal", {31'b0, ill_v}, 32'h1);
      check("R7 fp-only flags", rdata_f, 32'h1F);
      op(1'b1, 1'b0, 12'h002, 32'h0);
      check("R7 vec-only frm illegal", {31'b0, ill_v}, 32'h1);
      op(1'b1, 1'b0, 12'h009, 32'h0);
      check("R7 fp-only sat illegal", {31'b0, ill_f}, 32'h1);
      check("R7 vec-only sat", rdata_v, 32'h1);
      op(1'b1, 1'b0, 12'hC20, 32'h0);
      check("R7 fp-only length illegal", {31'b0, ill_f}, 32'h1);

      // R9 reset in mid-run clears fields
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      op(1'b1, 1'b0, 12'h003, 32'h0);
      check("R9 packed cleared", rdata, 32'h0);
      op(1'b1, 1'b0, 12'hC20, 32'h0);
      check("R9 length cleared", rdata, 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule